// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block sets the pace of SDRAM refresh. A 12-bit down-counter runs on the memory-interface clock, which is half the CPU clock. When the counter reaches zero it reloads itself from a programmable period. On that reload the block raises a one-cycle interrupt pulse. It also asks a downstream refresh scheduler for a burst of one to four refresh cycles. Because of the interrupt pulse, the block also works as a plain periodic timer on systems with no SDRAM attached.

Software sees a single 32-bit register through a simple write strobe and an always-valid read bus:

| Bits | Access | Content |
|------|--------|---------|
| 11:0 | read/write | reload period |
| 23:12 | read-only | live counter value, readable at any time |
| 25:24 | read/write | burst-size field |
| 31:26 | read-only | reserved, reads as zero |

Refresh requests leave through a valid/acknowledge handshake. Requests that are not yet granted build up in a saturating pending count, so an expiry is never lost while an earlier burst is still being served.

Top module: `refresh_interval_timer`

## Requirements
- R1: The read bus always shows the period in bits 11:0, the live counter in bits 23:12 and the burst-size field in bits 25:24. Bits 31:26 read as zero.
- R2: After reset, the period and the counter both hold 0x5DC (1500), the burst-size field holds 0, `ref_req_valid` is low and `tick_irq` is low.
- R3: While the counter is nonzero, it decreases by exactly one on every clock.
- R4: In the clock after the counter reads zero, the counter holds the period value that was in force during the zero cycle.
- R5: `tick_irq` is high for exactly the cycle in which the counter first shows its reloaded value, and is low in every other cycle. With a period of 0 the counter expires every cycle, so the pulse stays high.
- R6: Each expiry adds (burst-size field + 1) refreshes to the pending count, using the field value in force during the zero cycle. `ref_req_valid` is high whenever the pending count is nonzero.
- R7: Each clock with both `ref_req_valid` and `ref_req_ack` high removes one refresh from the pending count. An acknowledge while valid is low has no effect.
- R8: The pending count saturates at PEND_MAX (15 by default) and never wraps.
- R9: A write to the period field leaves the running count untouched. The new period is used only at the next reload.
- R10: Write data in bits 23:12 and 31:26 is ignored. A write changes only the period and the burst-size field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data, always valid |
| ref_req_valid | output | 1 | At least one refresh is pending |
| ref_req_ack | input | 1 | Scheduler accepts one refresh |
| tick_irq | output | 1 | One-cycle expiry interrupt |

## Verification
The embedded assertions watch the following on every cycle:
- the one-per-clock decrement and the reload from the period;
- that the interrupt pulse ends after a single cycle whenever the period is nonzero;
- that the pending count goes down by one per accepted acknowledge;
- that the pending count rises by the burst size on an expiry and never passes its ceiling;
- that the software-visible fields do not change without a write.

Only the bench scenarios show end-to-end properties. These are the exact 1501-cycle wait to the first expiry after reset, and that a mid-count period write shows up only at the following reload. They also include the readback that drops writes to the counter and reserved bits, and that a saturated burst drains in exactly PEND_MAX grants. A cycle-by-cycle reference model driven by random writes and acknowledges covers how the fields interact when they change together.

// File: rtl/rit_pkg.sv
package rit_pkg;
    parameter int CNT_W = 12;
    parameter int XR_W = 2;
    parameter int REG_W = 32;
    parameter logic [CNT_W-1:0] RESET_PERIOD = 12'h5DC;

    localparam int PER_LSB = 0;
    localparam int CNT_LSB = PER_LSB + CNT_W;
    localparam int XR_LSB  = CNT_LSB + CNT_W;
    localparam int RSV_LSB = XR_LSB + XR_W;
    localparam int RSV_W   = REG_W - RSV_LSB;
    localparam int ADD_W   = XR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [XR_W-1:0]  burst;
    } cfg_t;
endpackage

// File: rtl/rit_counter.sv
module rit_counter
    import rit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.count == '0) begin
            st_d.count = period_i;
            st_d.irq   = 1'b1;
        end else begin
            st_d.count = st_q.count - CNT_W'(1);
            st_d.irq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= RESET_PERIOD;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign expire_o = (st_q.count == '0);
    assign irq_o    = st_q.irq;

    assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |=> (count_o == $past(period_i)));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && count_o != '0) |=> !irq_o);
endmodule

// File: rtl/rit_pending.sv
module rit_pending
    import rit_pkg::*;
#(
    parameter int PEND_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire_i,
    input  logic [ADD_W-1:0] add_i,
    input  logic             ack_i,
    output logic             valid_o
);
    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam int SUM_W  = PEND_W + ADD_W;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic             take;

    always_comb begin
        st_d = st_q;
        take = ack_i && (st_q.pend != '0);
        sum  = SUM_W'(st_q.pend)
             + (expire_i ? SUM_W'(add_i) : SUM_W'(0))
             - SUM_W'(take);
        if (sum > SUM_W'(PEND_MAX)) begin
            st_d.pend = PEND_W'(PEND_MAX);
        end else begin
            st_d.pend = sum[PEND_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = (st_q.pend != '0);

    assert_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && valid_o && !expire_i) |=> (st_q.pend == $past(st_q.pend) - PEND_W'(1)));

    assert_burst_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !(ack_i && valid_o) && (int'(st_q.pend) + int'(add_i) <= PEND_MAX))
        |=> (int'(st_q.pend) == int'($past(st_q.pend)) + int'($past(add_i))));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.pend) <= PEND_MAX);

    assert_valid_after_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> valid_o);
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import rit_pkg::*;
#(
    parameter int PEND_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             ref_req_valid,
    input  logic             ref_req_ack,
    output logic             tick_irq
);
    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] count;
    logic             expire;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_en) begin
            cfg_d.period = reg_wr_data[PER_LSB +: CNT_W];
            cfg_d.burst  = reg_wr_data[XR_LSB +: XR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.period <= RESET_PERIOD;
            cfg_q.burst  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    rit_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (cfg_q.period),
        .count_o  (count),
        .expire_o (expire),
        .irq_o    (tick_irq)
    );

    rit_pending #(.PEND_MAX(PEND_MAX)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .add_i    (ADD_W'(cfg_q.burst) + ADD_W'(1)),
        .ack_i    (ref_req_ack),
        .valid_o  (ref_req_valid)
    );

    assign reg_rd_data = {{RSV_W{1'b0}}, cfg_q.burst, count, cfg_q.period};

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> ($stable(reg_rd_data[PER_LSB +: CNT_W]) && $stable(reg_rd_data[XR_LSB +: XR_W])));

    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data[PER_LSB +: CNT_W] == $past(reg_wr_data[PER_LSB +: CNT_W])));
endmodule

// File: tb/tb_refresh_interval_timer.sv
module tb_refresh_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int PMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        ref_req_valid;
    logic        ref_req_ack = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    refresh_interval_timer #(.PEND_MAX(PMAX)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .ref_req_valid(ref_req_valid),
        .ref_req_ack(ref_req_ack), .tick_irq(tick_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    logic [11:0] m_cnt, m_per;
    logic [1:0]  m_x;
    logic        m_irq;
    int          m_pend;

    function automatic logic [31:0] pack_reg(logic [1:0] x, logic [11:0] c, logic [11:0] p);
        return {6'b0, x, c, p};
    endfunction

    function automatic int next_pend(int p, bit exp, logic [1:0] x, bit ack);
        int t;
        t = p + (exp ? int'(x) + 1 : 0) - ((ack && p > 0) ? 1 : 0);
        return (t > PMAX) ? PMAX : t;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 12'h5DC; m_per <= 12'h5DC; m_x <= 2'd0; m_irq <= 1'b0; m_pend <= 0;
        end else begin
            if (m_cnt == 12'd0) begin m_cnt <= m_per; m_irq <= 1'b1; end
            else begin m_cnt <= m_cnt - 12'd1; m_irq <= 1'b0; end
            if (reg_wr_en) begin m_per <= reg_wr_data[11:0]; m_x <= reg_wr_data[25:24]; end
            m_pend <= next_pend(m_pend, m_cnt == 12'd0, m_x, ref_req_ack);
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            #2;
            check("R1,R9,R10 readback", reg_rd_data, pack_reg(m_x, m_cnt, m_per));
            check("R3,R4 counter", {20'b0, reg_rd_data[23:12]}, {20'b0, m_cnt});
            check("R5 irq", {31'b0, tick_irq}, {31'b0, m_irq});
            check("R6,R7,R8 valid", {31'b0, ref_req_valid}, {31'b0, m_pend != 0});
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        int n;
        logic [11:0] c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset reg", reg_rd_data, 32'h005DC5DC);
        check("R2 reset valid", {31'b0, ref_req_valid}, 32'd0);
        check("R2 reset irq", {31'b0, tick_irq}, 32'd0);

        // First expiry after 1501 clocks
        k = 0;
        do begin @(negedge clk); k++; end while (!tick_irq && k < 3000);
        check("R4,R5 first expiry cycle", k, 1501);
        check("R4 reloaded count", {20'b0, reg_rd_data[23:12]}, 32'h5DC);
        check("R6 one refresh pending", {31'b0, ref_req_valid}, 32'd1);
        @(negedge clk);
        check("R5 irq single cycle", {31'b0, tick_irq}, 32'd0);

        // One acknowledge drains the single request
        ref_req_ack = 1'b1;
        @(negedge clk);
        ref_req_ack = 1'b0;
        check("R7 grant clears", {31'b0, ref_req_valid}, 32'd0);

        // Mid-count write with junk in counter and reserved bits
        c = reg_rd_data[23:12];
        reg_wr_en = 1'b1;
        reg_wr_data = {6'h3F, 2'b01, 12'hABC, 12'h064};
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R9,R10 write leaves count", reg_rd_data, pack_reg(2'b01, c - 12'd1, 12'h064));
        k = 0;
        do begin @(negedge clk); k++; end while (!tick_irq && k < 3000);
        check("R9 new period at reload", {20'b0, reg_rd_data[23:12]}, 32'h064);

        // Two acks drain burst of two
        n = 0;
        ref_req_ack = 1'b1;
        while (ref_req_valid && n < 100) begin @(negedge clk); n++; end
        ref_req_ack = 1'b0;
        check("R6,R7 burst of two", n, 2);

        // Saturation: period 0, burst 4, no acks
        reg_wr_en = 1'b1;
        reg_wr_data = {6'h0, 2'b11, 12'h000, 12'h000};
        @(negedge clk);
        reg_wr_en = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (reg_rd_data[23:12] != 12'd0 && k < 200);
        repeat (10) @(negedge clk);
        check("R5 irq held with period 0", {31'b0, tick_irq}, 32'd1);
        reg_wr_en = 1'b1;
        reg_wr_data = {6'h0, 2'b11, 12'h000, 12'hFFF};
        @(negedge clk);
        reg_wr_en = 1'b0;
        @(negedge clk);
        n = 0;
        ref_req_ack = 1'b1;
        while (ref_req_valid && n < 100) begin @(negedge clk); n++; end
        ref_req_ack = 1'b0;
        check("R8 saturated drain", n, PMAX);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            reg_wr_en = ($urandom_range(0, 15) == 0);
            reg_wr_data = {$urandom_range(0, 63), 2'($urandom_range(0, 3)),
                           12'($urandom), 12'($urandom_range(0, 30))};
            ref_req_ack = ($urandom_range(0, 3) == 0);
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        ref_req_ack = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule